// File: doc/BRIEF.md
# Buffered-Reload PWM Generator

This block is a single-channel pulse-width modulator. Its prescaler setting, period modulus and duty value are held twice: in buffer registers that software may rewrite at any time, and in active registers that drive the counter and comparator. Software fills the buffers and then raises a load-okay flag with a read-then-write handshake. The hardware copies the buffers into the active set only at a qualifying reload point, and then clears the flag by itself.

Reload points are derived from reload opportunities. In edge-aligned mode an opportunity is the counter wrap. In center-aligned mode it is the bottom turnaround, and optionally the top turnaround as well. A 4-bit decimation field lets only every (F+1)-th opportunity become a reload. Each reload produces a one-cycle pulse on `reloadPulse`, whether or not a parameter load took place.

Top module: `pwmReloadGen`

## Requirements
- R1: After reset the block is in edge-aligned mode with modulus 8, duty value 4, prescale divide-by-1 and decimation field 0. `loadOkOut` and `reloadPulse` are 0 and `pwmOut` is 1.
- R2: In edge-aligned mode (control bit 0 = 0) the count runs 0..M-1 once per tick. The wrap is an opportunity. `pwmOut` is 1 while count < duty value, so each period holds duty-value high cycles.
- R3: In center-aligned mode (control bit 0 = 1) the count rises to M and falls back to 0, giving a period of 2M ticks. The turnaround at 0 is a full-cycle opportunity, and `pwmOut` is 1 while count < duty value.
- R4: The prescale field (control bits 3:2, value k) makes the counter advance once every 2^k clocks.
- R5: Writing 1 to control bit 4 sets `loadOkOut` only if `rdStb` was pulsed while `loadOkOut` was 0, after the previous control write. Any control write cancels a pending read.
- R6: The buffers are modulus (address 1), duty value (address 2) and prescale (address 0). They are copied to the active set only on a reload edge while the flag is set. The flag clears on that edge, and `reloadPulse` is high during the following cycle.
- R7: With decimation field F (address 3, bits 3:0) a reload happens on every (F+1)-th opportunity, regardless of the flag.
- R8: Writing address 3 restarts the opportunity count from zero.
- R9: Control bit 1 adds the top turnaround (count = M) as an opportunity in center-aligned mode. In edge-aligned mode it has no effect.
- R10: When a new modulus is loaded at a top-turnaround reload, the count becomes the new modulus minus one on that edge.
- R11: A buffer write that lands on the same edge as a loading reload does not reach the active set; the prior buffer content is loaded.

The modulus must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 modulus, 2 duty, 3 decimation |
| wrData | input | 16 | Write data |
| rdStb | input | 1 | Read strobe of the load-okay flag (arms the handshake) |
| loadOkOut | output | 1 | Current load-okay flag |
| reloadPulse | output | 1 | One-cycle pulse per reload |
| pwmOut | output | 1 | PWM output |

## Verification
Two things can fall on the same clock edge. One is a buffer write landing on a loading reload. The other is a decimation-field write landing on an opportunity, which can reset the opportunity count. The directed cases place a duty write exactly on the reload edge, and they judge the result by counting high cycles in the next period. They also rewrite the decimation field one opportunity after a reload and time the next pulse. A top-turnaround load is provoked after a bottom reload, identified from the output level, and the following count is read through the comparator. Random register traffic then runs against a cycle-level bench model that tracks every collision of writes, reads and opportunities.

// File: rtl/pwmRelPkg.sv
package pwmRelPkg;
  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_MOD  = 2'd1;
  localparam logic [1:0] REG_VAL  = 2'd2;
  localparam logic [1:0] REG_FREQ = 2'd3;

  typedef struct packed {
    logic tick;   // counter advances this cycle
    logic load;   // copy buffers into active set at this edge
  } pwmStrb_t;
endpackage

// File: rtl/pwmRelCtl.sv
module pwmRelCtl
  import pwmRelPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 2,
  parameter int FREQ_W  = 4,
  parameter int DEF_MOD = 8,
  parameter int DEF_VAL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdStb,
  input  logic             oppFull,
  input  logic             oppHalf,
  input  logic [PSC_W-1:0] actPsc,
  output pwmStrb_t         strb,
  output logic [PSC_W-1:0] bufPsc,
  output logic [CNT_W-1:0] bufMod,
  output logic [CNT_W-1:0] bufVal,
  output logic             centerQ,
  output logic             loadOkQ,
  output logic             reloadQ
);
  localparam int PRE_W  = (1 << PSC_W) - 1;
  localparam int OK_BIT = PSC_W + 2;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W:0]    maskW;
  logic [PRE_W-1:0]  mask;
  logic [FREQ_W-1:0] freqQ, oppCnt;
  logic              halfQ, armedQ;
  logic              ctlWr, freqWr, opp, reloadEvt;

  always_comb begin
    maskW = ({{PRE_W{1'b0}}, 1'b1} << actPsc) - 1'b1;
    mask  = maskW[PRE_W-1:0];
  end

  assign ctlWr     = wrEn && (wrAddr == REG_CTL);
  assign freqWr    = wrEn && (wrAddr == REG_FREQ);
  assign strb.tick = ((preCnt & mask) == mask);
  assign opp       = strb.tick && (oppFull || (halfQ && oppHalf));
  assign reloadEvt = opp && (oppCnt == freqQ);
  assign strb.load = reloadEvt && loadOkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      centerQ <= 1'b0;
      halfQ   <= 1'b0;
      bufPsc  <= '0;
      bufMod  <= CNT_W'(DEF_MOD);
      bufVal  <= CNT_W'(DEF_VAL);
      freqQ   <= '0;
      oppCnt  <= '0;
      armedQ  <= 1'b0;
      loadOkQ <= 1'b0;
      reloadQ <= 1'b0;
    end else begin
      preCnt  <= preCnt + 1'b1;
      reloadQ <= reloadEvt;
      if (ctlWr) begin
        centerQ <= wrData[0];
        halfQ   <= wrData[1];
        bufPsc  <= wrData[PSC_W+1:2];
      end
      if (wrEn && (wrAddr == REG_MOD)) bufMod <= wrData;
      if (wrEn && (wrAddr == REG_VAL)) bufVal <= wrData;
      if (freqWr) begin
        freqQ  <= wrData[FREQ_W-1:0];
        oppCnt <= '0;
      end else if (opp) begin
        oppCnt <= reloadEvt ? '0 : oppCnt + 1'b1;
      end
      if (ctlWr)                  armedQ <= 1'b0;
      else if (rdStb && !loadOkQ) armedQ <= 1'b1;
      if (strb.load)                            loadOkQ <= 1'b0;
      else if (ctlWr && wrData[OK_BIT] && armedQ) loadOkQ <= 1'b1;
    end
  end

  // R5: the flag can only rise after an armed read
  p_ok_needs_arm_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadOkQ) |-> $past(armedQ));
  // R6: a load clears the flag
  p_ok_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !loadOkQ);
  // R8: a decimation write restarts the opportunity count
  p_freq_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    freqWr |=> (oppCnt == '0));
endmodule

// File: rtl/pwmRelDp.sv
module pwmRelDp
  import pwmRelPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 2,
  parameter int DEF_MOD = 8,
  parameter int DEF_VAL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrb_t         strb,
  input  logic [PSC_W-1:0] bufPsc,
  input  logic [CNT_W-1:0] bufMod,
  input  logic [CNT_W-1:0] bufVal,
  input  logic             centerMode,
  output logic             oppFull,
  output logic             oppHalf,
  output logic [PSC_W-1:0] actPsc,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt, actMod, actVal, modNext;
  logic             downQ;

  assign modNext = strb.load ? bufMod : actMod;
  assign oppFull = centerMode ? (downQ && (cnt == '0)) : (cnt >= actMod - 1'b1);
  assign oppHalf = centerMode && !downQ && (cnt >= actMod);
  assign pwmOut  = (cnt < actVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      downQ  <= 1'b0;
      actPsc <= '0;
      actMod <= CNT_W'(DEF_MOD);
      actVal <= CNT_W'(DEF_VAL);
    end else begin
      if (strb.tick) begin
        if (oppFull) begin
          cnt   <= centerMode ? CNT_W'(1) : '0;
          downQ <= 1'b0;
        end else if (oppHalf) begin
          cnt   <= modNext - 1'b1;
          downQ <= 1'b1;
        end else if (centerMode && downQ) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (strb.load) begin
        actPsc <= bufPsc;
        actMod <= bufMod;
        actVal <= bufVal;
      end
    end
  end

  // R6: a load copies the buffers seen at that edge
  p_load_copies_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (actMod == $past(bufMod)) && (actVal == $past(bufVal)));
  // R10: a top-turnaround load lands the count on the new modulus minus one
  p_half_force_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && oppHalf && strb.load) |=> (cnt == actMod - 1'b1));
endmodule

// File: rtl/pwmReloadGen.sv
module pwmReloadGen
  import pwmRelPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 2,
  parameter int FREQ_W  = 4,
  parameter int DEF_MOD = 8,
  parameter int DEF_VAL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdStb,
  output logic             loadOkOut,
  output logic             reloadPulse,
  output logic             pwmOut
);
  pwmStrb_t         strb;
  logic [PSC_W-1:0] bufPsc, actPsc;
  logic [CNT_W-1:0] bufMod, bufVal;
  logic             centerQ, oppFull, oppHalf;

  pwmRelCtl #(.CNT_W(CNT_W), .PSC_W(PSC_W), .FREQ_W(FREQ_W),
              .DEF_MOD(DEF_MOD), .DEF_VAL(DEF_VAL)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .oppFull(oppFull), .oppHalf(oppHalf), .actPsc(actPsc),
    .strb(strb), .bufPsc(bufPsc), .bufMod(bufMod), .bufVal(bufVal),
    .centerQ(centerQ), .loadOkQ(loadOkOut), .reloadQ(reloadPulse));

  pwmRelDp #(.CNT_W(CNT_W), .PSC_W(PSC_W),
             .DEF_MOD(DEF_MOD), .DEF_VAL(DEF_VAL)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .bufPsc(bufPsc), .bufMod(bufMod),
    .bufVal(bufVal), .centerMode(centerQ), .oppFull(oppFull),
    .oppHalf(oppHalf), .actPsc(actPsc), .pwmOut(pwmOut));
endmodule

// File: tb/tb_pwmReloadGen.sv
module tb_pwmReloadGen;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdStb = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic loadOkOut, reloadPulse, pwmOut;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int cCen = 0, cHalf = 0, cPsc = 0;

  // bench reference state
  int mCnt, mDown, mMod, mVal, mPsc, bMod, bVal, bPsc;
  int mCen, mHalf, mFreq, mOpp, mOk, mArm, mRel, mPre;

  always #(CLK_P/2) clk = ~clk;

  pwmReloadGen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .loadOkOut(loadOkOut), .reloadPulse(reloadPulse),
    .pwmOut(pwmOut));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlWord(input int ok);
    return 16'(cCen | (cHalf << 1) | (cPsc << 2) | (ok << 4));
  endfunction

  // cycle model written from the requirements
  always @(posedge clk) begin : refModel
    int tk, fu, ha, op, re, ld, nm, okOld;
    if (!rstN) begin
      mCnt = 0; mDown = 0; mMod = 8; mVal = 4; mPsc = 0;
      bMod = 8; bVal = 4; bPsc = 0; mCen = 0; mHalf = 0;
      mFreq = 0; mOpp = 0; mOk = 0; mArm = 0; mRel = 0; mPre = 0;
    end else begin
      tk = ((mPre % (1 << mPsc)) == ((1 << mPsc) - 1)) ? 1 : 0;
      fu = mCen ? ((mDown != 0 && mCnt == 0) ? 1 : 0) : ((mCnt + 1 >= mMod) ? 1 : 0);
      ha = (mCen != 0 && mDown == 0 && mCnt >= mMod) ? 1 : 0;
      op = (tk != 0 && (fu != 0 || (ha != 0 && mHalf != 0))) ? 1 : 0;
      re = (op != 0 && mOpp == mFreq) ? 1 : 0;
      ld = (re != 0 && mOk != 0) ? 1 : 0;
      nm = ld ? bMod : mMod;
      okOld = mOk;
      if (tk != 0) begin
        if (fu != 0) begin mCnt = mCen ? 1 : 0; mDown = 0; end
        else if (ha != 0) begin mCnt = nm - 1; mDown = 1; end
        else if (mCen != 0 && mDown != 0) mCnt = mCnt - 1;
        else mCnt = mCnt + 1;
      end
      if (ld != 0) begin mPsc = bPsc; mMod = bMod; mVal = bVal; end
      if (ld != 0) mOk = 0;
      else if (wrEn && wrAddr == 2'd0 && wrData[4] && mArm != 0) mOk = 1;
      if (wrEn && wrAddr == 2'd0) mArm = 0;
      else if (rdStb && okOld == 0) mArm = 1;
      if (wrEn && wrAddr == 2'd0) begin
        mCen = int'(wrData[0]); mHalf = int'(wrData[1]); bPsc = int'(wrData[3:2]);
      end
      if (wrEn && wrAddr == 2'd1) bMod = int'(wrData);
      if (wrEn && wrAddr == 2'd2) bVal = int'(wrData);
      if (wrEn && wrAddr == 2'd3) begin mFreq = int'(wrData[3:0]); mOpp = 0; end
      else if (op != 0) mOpp = re ? 0 : mOpp + 1;
      mRel = re;
      mPre = (mPre + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(mCen != 0 ? "R3 pwm level" : "R2 pwm level", int'(pwmOut), (mCnt < mVal) ? 1 : 0);
      chk("R7 reload pulse", int'(reloadPulse), mRel);
      chk("R5 flag level", int'(loadOkOut), mOk);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic setOk();
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk); rdStb = 1'b0; wrEn = 1'b1; wrAddr = 2'd0; wrData = ctlWord(1);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitPulse();
    int g = 0;
    do begin @(negedge clk); g++; end while (!reloadPulse && g < 3000);
    if (!reloadPulse) chk("R7 pulse timeout", 0, 1);
  endtask

  task automatic measure(output int n);
    waitPulse();
    n = 0;
    do begin @(negedge clk); n++; end while (!reloadPulse && n < 3000);
  endtask

  task automatic loadParams(input int psc, input int md, input int vl);
    int g = 0;
    wr(2'd1, 16'(md)); wr(2'd2, 16'(vl)); cPsc = psc;
    setOk();
    while (loadOkOut && g < 3000) begin @(negedge clk); g++; end
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      chk("watchdog expired", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int n, h, g;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwm", int'(pwmOut), 1);
    chk("R1 flag", int'(loadOkOut), 0);
    chk("R1 pulse", int'(reloadPulse), 0);
    rstN = 1'b1;

    // R5 handshake
    wr(2'd3, 16'd15);
    wr(2'd0, ctlWord(1));
    chk("R5 unarmed write", int'(loadOkOut), 0);
    setOk();
    chk("R5 armed write", int'(loadOkOut), 1);
    g = 0;
    while (loadOkOut && g < 400) begin @(negedge clk); g++; end
    chk("R6 flag clears with reload", int'(reloadPulse), 1);
    wr(2'd3, 16'd0);

    // R2 edge-aligned period and duty
    loadParams(0, 5, 2);
    h = int'(pwmOut);
    repeat (4) begin @(negedge clk); h += int'(pwmOut); end
    chk("R2 high cycles", h, 2);
    measure(n); chk("R2 period", n, 5);

    // R4 prescale divide by 8
    loadParams(3, 3, 1);
    measure(n); chk("R4 prescaled period", n, 24);

    // R7 decimation
    loadParams(0, 4, 1);
    wr(2'd3, 16'd3);
    measure(n); chk("R7 every fourth", n, 16);

    // R8 decimation write restarts count
    waitPulse();
    repeat (4) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd3; wrData = 16'd1;
    @(negedge clk); wrEn = 1'b0;
    n = 5;
    while (!reloadPulse && n < 3000) begin @(negedge clk); n++; end
    chk("R8 restart interval", n, 12);
    wr(2'd3, 16'd0);

    // R9 half-cycle opportunities and R3 center period
    cCen = 1; cHalf = 1; wr(2'd0, ctlWord(0));
    loadParams(0, 4, 1);
    measure(n); measure(n); chk("R9 center with half", n, 4);
    cHalf = 0; wr(2'd0, ctlWord(0));
    measure(n); measure(n); chk("R3 center period", n, 8);
    cCen = 0; cHalf = 1; wr(2'd0, ctlWord(0));
    measure(n); measure(n); chk("R9 edge half ignored", n, 4);

    // R10 modulus load at top turnaround
    cCen = 1; cHalf = 1; wr(2'd0, ctlWord(0));
    loadParams(0, 4, 2);
    wr(2'd1, 16'd6); wr(2'd2, 16'd5);
    g = 0;
    do begin waitPulse(); g++; end while (!pwmOut && g < 10);
    setOk();
    @(negedge clk);
    chk("R10 reload at top", int'(reloadPulse), 1);
    chk("R10 count new mod minus one", int'(pwmOut), 0);
    chk("R6 flag cleared", int'(loadOkOut), 0);
    @(negedge clk);
    chk("R10 count descends", int'(pwmOut), 1);

    // R11 buffer write on the reload edge
    cCen = 0; cHalf = 0; wr(2'd0, ctlWord(0));
    loadParams(0, 4, 1);
    wr(2'd2, 16'd3);
    waitPulse();
    setOk();
    wrEn = 1'b1; wrAddr = 2'd2; wrData = 16'd0;
    @(negedge clk); wrEn = 1'b0;
    chk("R6 loading reload", int'(reloadPulse), 1);
    h = int'(pwmOut);
    repeat (3) begin @(negedge clk); h += int'(pwmOut); end
    chk("R11 prior buffer loaded", h, 3);

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      wrEn = 1'b0; rdStb = 1'b0;
      r = int'($urandom % 100);
      if (r < 10) begin
        wrEn = 1'b1;
        wrAddr = 2'($urandom % 4);
        case (wrAddr)
          2'd0: wrData = 16'($urandom % 32);
          2'd1: wrData = 16'(2 + $urandom % 11);
          2'd2: wrData = 16'($urandom % 14);
          default: wrData = 16'($urandom % 16);
        endcase
      end else if (r < 18) begin
        rdStb = 1'b1;
      end
    end
    @(negedge clk); wrEn = 1'b0; rdStb = 1'b0;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule